// File: doc/BRIEF.md
# Two-Wire Page-Write Memory Target

This block is a target on a two-wire serial bus (clock line and open-drain data line) that accepts write transfers into a small on-chip byte array. Both bus lines are sampled with the system clock, passed through a two-stage synchronizer, and then edge-detected. A START or STOP is an edge on the data line while the clock line is high. Bits are taken on rising clock-line edges, most significant bit first. The block pulls the data line low in the ninth clock of a byte to acknowledge it, and it changes the data line only while the clock line is low.

A write transfer has four parts. It opens with the device word `1010_000_0`, which holds a fixed `1010` prefix, three zero bits and a clear read/write bit. Two word-address bytes follow, high byte first, and then any number of data bytes. The data bytes collect in a page buffer. Each byte steps only the low six bits of the word address, so the transfer stays inside one 64-byte page. A STOP after at least one data byte writes the buffered bytes into the array and starts a write interval of `WRITE_CYCLES` system clocks. During that interval `busy_o` is high and the bus is ignored. A lookup port returns the contents of the array, so the result of a write can be observed.

Top module: `twi_mem_writer`

## Requirements
- R1: A device word equal to 8'b1010_0000 is acknowledged. `sda_pull_o` rises 3 clocks after the `scl_i` falling edge that ends the eighth bit. It falls 3 clocks after the `scl_i` falling edge that ends the ninth clock. It changes only while `scl_i` is low.
- R2: The block does not acknowledge any other device word. This covers a set read bit (bit 0 = 1), a nonzero bit in positions 3..1 and a wrong prefix. After such a word, no further byte is acknowledged until the next START.
- R3: After an accepted device word, both word-address bytes and every data byte are acknowledged with the timing of R1.
- R4: The first data byte goes to the word address. Each later byte goes to the next address in which only the low 6 bits have been incremented, so the address wraps from offset 63 to offset 0 of the same page.
- R5: When more than 64 data bytes are sent, a byte that lands on an offset already written in the same transfer replaces the earlier byte.
- R6: A STOP after at least one data byte writes the page buffer into the array. `busy_o` rises 3 clocks after the SDA rising edge of that STOP and stays high for exactly `WRITE_CYCLES` clocks.
- R7: While `busy_o` is high, `sda_pull_o` stays low whatever the bus does, and bus activity leaves the array unchanged.
- R8: A STOP or a repeated START that comes before any data byte ends the transfer without raising `busy_o` and without changing the array.
- R9: After reset, `sda_pull_o` and `busy_o` are low and every array byte reads as 0.
- R10: Word-address bits at or above `MEM_AW` are ignored, so the target byte is the word address modulo the array size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | High to pull the data line low |
| busy_o | output | 1 | High during the timed write interval |
| peek_addr_i | input | MEM_AW | Array address for lookup |
| peek_data_o | output | 8 | Array byte at `peek_addr_i`, combinational |

## Verification
Every bus edge takes two synchronizer clocks and one edge-detect clock to act. The acknowledge level therefore changes on the third clock after the clock-line edge that causes it, and `busy_o` rises on the third clock after the data-line rise of the STOP. The reference model in the bench compares both outputs on every clock, 1 ns after the rising edge. It masks `sda_pull_o` for four clocks after each change it predicts, and it schedules `busy_o` to the exact clock. Array contents are compared through the lookup port only after the predicted write interval has ended.

// File: rtl/twi_mem_pkg.sv
// Shared types and constants for the two-wire page-write target.
// Assumes: one fixed device word; writes only.
package twi_mem_pkg;

    // Device word that selects this target for a write transfer
    localparam logic [7:0] DEV_WRITE_WORD = 8'b1010_0000;

    // Transfer phase: which byte of the frame is being received
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_ADDR_HI,
        PH_ADDR_LO,
        PH_DATA,
        PH_SKIP
    } phase_t;

endpackage

// File: rtl/twi_line_sync.sv
// Synchronizes the asynchronous bus lines and derives one-cycle event strobes.
// Assumes the lines idle high; each event appears 2 clocks after the pin edge.
module twi_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);
    logic [1:0] scl_sy;
    logic [1:0] sda_sy;
    logic       scl_q;
    logic       sda_q;

    // Two-stage synchronizers plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sy <= 2'b11;
            sda_sy <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sy <= {scl_sy[0], scl_i};
            sda_sy <= {sda_sy[0], sda_i};
            scl_q  <= scl_sy[1];
            sda_q  <= sda_sy[1];
        end
    end

    // Edge strobes; START and STOP need the clock line high before and after
    always_comb begin
        scl_rise  = scl_sy[1] & ~scl_q;
        scl_fall  = ~scl_sy[1] & scl_q;
        start_det = scl_sy[1] & scl_q & sda_q & ~sda_sy[1];
        stop_det  = scl_sy[1] & scl_q & ~sda_q & sda_sy[1];
        sda_bit   = sda_sy[1];
    end
endmodule

// File: rtl/twi_write_timer.sv
// Counts the timed write interval after a commit.
// Assumes CYCLES >= 1; busy is high for exactly CYCLES clocks after kick.
module twi_write_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    // Load on kick, count down while busy, drop busy when the count is spent
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (kick) begin
            busy   <= 1'b1;
            remain <= CW'(CYCLES - 1);
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/twi_page_store.sv
// Page buffer with per-byte fill flags, plus the byte array it commits into.
// Assumes PAGE_AW < MEM_AW; buffer clear and fill never coincide with commit.
module twi_page_store #(
    parameter int MEM_AW  = 8,
    parameter int PAGE_AW = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      buf_clr,
    input  logic                      buf_we,
    input  logic [PAGE_AW-1:0]        buf_off,
    input  logic [7:0]                buf_data,
    input  logic                      commit,
    input  logic [MEM_AW-PAGE_AW-1:0] page_base,
    input  logic [MEM_AW-1:0]         peek_addr,
    output logic [7:0]                peek_data
);
    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam int MEM_BYTES  = 1 << MEM_AW;

    logic [7:0]            page_buf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] filled;
    logic [7:0]            mem [MEM_BYTES];

    // Fill flags: cleared at the start of a data phase, set per written byte
    always_ff @(posedge clk) begin
        if (!rst_n)      filled <= '0;
        else if (buf_clr) filled <= '0;
        else if (buf_we)  filled[buf_off] <= 1'b1;
    end

    // Buffer bytes: a later byte at the same offset replaces an earlier one
    always_ff @(posedge clk) begin
        if (buf_we) page_buf[buf_off] <= buf_data;
    end

    // Array: cleared by reset, receives every filled buffer byte on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
        end else if (commit) begin
            for (int j = 0; j < PAGE_BYTES; j++)
                if (filled[j]) mem[{page_base, PAGE_AW'(j)}] <= page_buf[j];
        end
    end

    // Lookup of the array
    always_comb peek_data = mem[peek_addr];
endmodule

// File: rtl/twi_mem_writer.sv
// Two-wire write target: matches the device word, takes a 16-bit word
// address, buffers data bytes in one page and commits them on STOP.
// Assumes PAGE_AW < MEM_AW <= 16 and the bus is slow against clk.
module twi_mem_writer
    import twi_mem_pkg::*;
#(
    parameter int WRITE_CYCLES = 2000,
    parameter int MEM_AW       = 8,
    parameter int PAGE_AW      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic              busy_o,
    input  logic [MEM_AW-1:0] peek_addr_i,
    output logic [7:0]        peek_data_o
);
    localparam int PW = MEM_AW - PAGE_AW;

    logic               scl_rise, scl_fall, start_det, stop_det, sda_bit;
    logic               busy;
    phase_t             phase;
    logic [7:0]         shreg;
    logic [7:0]         addr_hi;
    logic [3:0]         bit_cnt;
    logic               ack_slot;
    logic               pull;
    logic               got_data;
    logic [PAGE_AW-1:0] offset;
    logic [PW-1:0]      page;
    logic               bus_live, byte_done, buf_we, buf_clr, commit;

    twi_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit)
    );

    twi_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .kick(commit), .busy(busy)
    );

    twi_page_store #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .buf_clr(buf_clr), .buf_we(buf_we), .buf_off(offset), .buf_data(shreg),
        .commit(commit), .page_base(page),
        .peek_addr(peek_addr_i), .peek_data(peek_data_o)
    );

    // Event qualifiers: a byte is complete on the clock fall after its eighth bit
    always_comb begin
        bus_live  = !busy && !start_det && !stop_det && (phase != PH_IDLE);
        byte_done = bus_live && scl_fall && !ack_slot && (bit_cnt == 4'd8);
        buf_we    = byte_done && (phase == PH_DATA);
        buf_clr   = byte_done && (phase == PH_ADDR_LO);
        commit    = !busy && stop_det && (phase == PH_DATA) && got_data;
    end

    // Frame sequencer: bit shifting, byte decode, acknowledge drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            shreg    <= '0;
            addr_hi  <= '0;
            bit_cnt  <= '0;
            ack_slot <= 1'b0;
            pull     <= 1'b0;
            got_data <= 1'b0;
            offset   <= '0;
            page     <= '0;
        end else if (busy) begin
            phase    <= PH_IDLE;
            pull     <= 1'b0;
            ack_slot <= 1'b0;
            bit_cnt  <= '0;
            got_data <= 1'b0;
        end else if (start_det) begin
            phase    <= PH_DEV;
            pull     <= 1'b0;
            ack_slot <= 1'b0;
            bit_cnt  <= '0;
            got_data <= 1'b0;
        end else if (stop_det) begin
            phase    <= PH_IDLE;
            pull     <= 1'b0;
            ack_slot <= 1'b0;
            bit_cnt  <= '0;
        end else if (phase != PH_IDLE) begin
            if (scl_rise && !ack_slot && bit_cnt != 4'd8) begin
                shreg   <= {shreg[6:0], sda_bit};
                bit_cnt <= bit_cnt + 4'd1;
            end
            if (scl_fall && ack_slot) begin
                pull     <= 1'b0;
                ack_slot <= 1'b0;
                bit_cnt  <= '0;
            end else if (byte_done) begin
                ack_slot <= 1'b1;
                case (phase)
                    PH_DEV: begin
                        if (shreg == DEV_WRITE_WORD) begin
                            pull  <= 1'b1;
                            phase <= PH_ADDR_HI;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                    PH_ADDR_HI: begin
                        addr_hi <= shreg;
                        pull    <= 1'b1;
                        phase   <= PH_ADDR_LO;
                    end
                    PH_ADDR_LO: begin
                        offset <= shreg[PAGE_AW-1:0];
                        page   <= PW'({addr_hi, shreg} >> PAGE_AW);
                        pull   <= 1'b1;
                        phase  <= PH_DATA;
                    end
                    PH_DATA: begin
                        offset   <= offset + 1'b1;
                        got_data <= 1'b1;
                        pull     <= 1'b1;
                    end
                    default: pull <= 1'b0;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        sda_pull_o = pull;
        busy_o     = busy;
    end
endmodule

// File: rtl/twi_mem_writer_chk.sv
// Protocol checker for twi_mem_writer, attached by bind below.
// Assumes the bus holds each level for more than three system clocks.
module twi_mem_writer_chk #(
    parameter int WRITE_CYCLES = 2000
) (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic sda_pull_o,
    input logic busy_o
);
    int run_len;

    // Length of the current busy run, in clocks
    always_ff @(posedge clk) begin
        if (!rst_n) run_len <= 0;
        else        run_len <= busy_o ? run_len + 1 : 0;
    end

    // R9: quiet outputs on the first cycle after reset
    a_r9_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!sda_pull_o && !busy_o));

    // R1: acknowledge is asserted only while the clock line is low
    a_r1_pull_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_i);

    // R1: acknowledge is released only while the clock line is low
    a_r1_pull_fall_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) |-> !scl_i);

    // R7: no acknowledge during the write interval
    a_r7_deaf_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_pull_o);

    // R6: busy begins three clocks after a data-line rise with the clock line high
    a_r6_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(sda_i, 3) && $past(scl_i, 3)));

    // R6: the write interval lasts exactly WRITE_CYCLES clocks
    a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_len == WRITE_CYCLES));
endmodule

bind twi_mem_writer twi_mem_writer_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_pull_o(sda_pull_o), .busy_o(busy_o)
);

// File: tb/twi_mem_writer_test.sv
// Bench: drives the bus as an open-drain controller and compares the outputs
// on every clock with a behavioural model of the expected ones.
module twi_mem_writer_test;
    localparam int W      = 800;
    localparam int MEM_AW = 8;
    localparam int HALF   = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_pull, busy;
    logic [7:0] peek_addr = 8'h00;
    logic [7:0] peek_data;
    wire        sda_line = m_sda & ~sda_pull;

    twi_mem_writer #(.WRITE_CYCLES(W), .MEM_AW(MEM_AW), .PAGE_AW(6)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .busy_o(busy),
        .peek_addr_i(peek_addr), .peek_data_o(peek_data)
    );

    int         vectors = 0;
    int         miscompares = 0;
    logic       exp_pull = 1'b0;
    logic       exp_busy = 1'b0;
    int         mask = 0;
    bit         cmp_on = 1'b0;
    logic [7:0] model [256];

    task automatic check(input string tag, input int act, input int exp, input string what);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Per-clock comparison 1 ns after the edge; pull masked after a predicted change
    always @(posedge clk) begin
        #1;
        if (cmp_on) begin
            if (mask > 0) mask--;
            else check("R3", int'(sda_pull), int'(exp_pull), "sda pull per clock");
            check("R6", int'(busy), int'(exp_busy), "busy per clock");
        end
    end

    task automatic set_pull(input logic v);
        if (v !== exp_pull) begin
            exp_pull = v;
            mask = 4;
        end
    endtask

    task automatic hold();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hold();
        m_scl = 1'b1; hold();
        m_sda = 1'b0; hold();
        m_scl = 1'b0; hold();
    endtask

    // Busy model: high from the third clock after the STOP edge for W clocks
    task automatic busy_model();
        repeat (2) @(negedge clk);
        exp_busy = 1'b1;
        repeat (W) @(negedge clk);
        exp_busy = 1'b0;
    endtask

    task automatic bus_stop(input bit commits);
        m_sda = 1'b0; hold();
        m_scl = 1'b1; hold();
        m_sda = 1'b1;
        if (commits) fork busy_model(); join_none
        hold();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit ack, input string tag);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hold();
            m_scl = 1'b1; hold();
            m_scl = 1'b0;
        end
        m_sda = 1'b1;
        set_pull(ack);
        hold();
        m_scl = 1'b1; hold();
        check(tag, int'(sda_pull), int'(ack), $sformatf("ack for byte 0x%02h", b));
        m_scl = 1'b0;
        set_pull(1'b0);
        hold();
    endtask

    task automatic check_mem(input string tag);
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            peek_addr = a[7:0];
            #1;
            check(tag, int'(peek_data), int'(model[a]), $sformatf("mem[%0d]", a));
        end
    endtask

    // Full write transfer; model updated with page-wrapped offsets (R4, R5, R10)
    task automatic write_tx(input logic [15:0] addr, input logic [7:0] d[$],
                            input string tag, input bit wait_done);
        int off;
        int pg;
        bus_start();
        send_byte(8'hA0, 1'b1, "R1");
        send_byte(addr[15:8], 1'b1, "R3");
        send_byte(addr[7:0], 1'b1, "R3");
        foreach (d[i]) send_byte(d[i], 1'b1, "R3");
        bus_stop(d.size() > 0);
        off = int'(addr[5:0]);
        pg  = int'(addr[7:6]);
        foreach (d[i]) begin
            model[pg * 64 + off] = d[i];
            off = (off + 1) % 64;
        end
        if (wait_done) begin
            repeat (W + 20) @(negedge clk);
            check_mem(tag);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] q[$];
        logic [7:0] bad[4];
        for (int a = 0; a < 256; a++) model[a] = 8'h00;
        repeat (5) @(negedge clk);
        // R9: reset state
        check("R9", int'(sda_pull), 0, "pull in reset");
        check("R9", int'(busy), 0, "busy in reset");
        rst_n  = 1'b1;
        cmp_on = 1'b1;
        repeat (4) @(negedge clk);
        check_mem("R9");

        // R1, R3, R6: single byte
        q.delete(); q.push_back(8'h5A);
        write_tx(16'h0010, q, "R6", 1'b1);

        // R4: page wrap from offset 56 across 63 to 0
        q.delete();
        for (int i = 0; i < 10; i++) q.push_back(8'(8'h80 + i));
        write_tx(16'h0038, q, "R4", 1'b1);

        // R5: 70 bytes overwrite the first six offsets written
        q.delete();
        for (int i = 0; i < 70; i++) q.push_back(8'(i * 7 + 3));
        write_tx(16'h0045, q, "R5", 1'b1);

        // R10: upper word-address bits ignored
        q.delete(); q.push_back(8'hE1); q.push_back(8'hE2);
        write_tx(16'h12F3, q, "R10", 1'b1);

        // R2: read bit, nonzero middle bits, wrong prefix
        bad[0] = 8'hA1; bad[1] = 8'hA2; bad[2] = 8'hB0; bad[3] = 8'h20;
        foreach (bad[k]) begin
            bus_start();
            send_byte(bad[k], 1'b0, "R2");
            send_byte(8'h00, 1'b0, "R2");
            send_byte(8'h11, 1'b0, "R2");
            bus_stop(1'b0);
        end
        repeat (20) @(negedge clk);
        check_mem("R2");

        // R8: STOP before data
        bus_start();
        send_byte(8'hA0, 1'b1, "R8");
        send_byte(8'h00, 1'b1, "R8");
        send_byte(8'h20, 1'b1, "R8");
        bus_stop(1'b0);
        repeat (50) @(negedge clk);
        check_mem("R8");

        // R8: repeated START before data, then a real write
        bus_start();
        send_byte(8'hA0, 1'b1, "R8");
        send_byte(8'h00, 1'b1, "R8");
        send_byte(8'h05, 1'b1, "R8");
        q.delete(); q.push_back(8'h77);
        write_tx(16'h0007, q, "R8", 1'b1);

        // R7: no acknowledge and no effect during the write interval
        q.delete(); q.push_back(8'hC3);
        write_tx(16'h0080, q, "R7", 1'b0);
        bus_start();
        send_byte(8'hA0, 1'b0, "R7");
        send_byte(8'h00, 1'b0, "R7");
        bus_stop(1'b0);
        repeat (W) @(negedge clk);
        check_mem("R7");
        q.delete(); q.push_back(8'h3C);
        write_tx(16'h0081, q, "R7", 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule